// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block owns the program counter of a single-cycle 32-bit processor whose instructions are all four bytes wide. Each cycle it looks at the instruction word being executed, the equality flag from the register comparator and the value read for the first source register. From these it picks the address of the next instruction and loads it into the PC on the following clock edge.

Five kinds of control flow are recognised. The default is to step forward by one instruction. There are two compare-and-branch forms (branch when equal, branch when different) that add a scaled signed offset to the incremented PC. There are two direct jumps that keep the top four bits of the incremented PC and replace the rest with a 26-bit field. The last is a register-indirect jump that takes the first source register value as the target. The call form of the direct jump also reports a return address and a write request aimed at register 31, which the register file consumes in the same cycle.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset loads the PC with the parameter `RESET_VEC` (default 0x0001_3880) on the next rising edge, whatever the instruction inputs are.
- R2: An instruction that is not one of the control-flow forms below makes the next PC equal to PC + 4.
- R3: Opcode (bits 31:26) 4 with the equality flag high makes the next PC equal to (PC + 4) + sign-extended bits 15:0 shifted left by two.
- R4: Opcode 5 with the equality flag low makes the next PC equal to (PC + 4) + sign-extended bits 15:0 shifted left by two; offset 0x7FFF and 0x8000 reach the extremes of the range.
- R5: Opcode 4 with the flag low, or opcode 5 with the flag high, falls through to PC + 4.
- R6: Opcode 2 makes the next PC equal to {(PC+4)[31:28], bits 25:0, 2'b00}; the top nibble comes from PC + 4, so it changes when PC + 4 crosses a 256 MiB boundary.
- R7: Opcode 3 jumps as R6 and in the same cycle raises `link_wr`, drives `link_value` with PC + 4 and `link_idx` with 31.
- R8: Opcode 0 with function field (bits 5:0) equal to 8 makes the next PC equal to `rs_value`.
- R9: `link_wr` is low for every instruction other than opcode 3.
- R10: `rs_value` has no effect unless the instruction is the register-indirect form; opcode 0 with another function code, or a non-zero opcode with bits 5:0 equal to 8, is sequential.
- R11: `pc_next` is combinational from the current PC and the inputs, and `pc_q` takes its value on each rising edge outside reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word executed this cycle |
| regs_equal | input | 1 | High when the two source registers compare equal |
| rs_value | input | 32 | Value of the first source register |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Address the PC takes at the next edge |
| link_wr | output | 1 | Register-file write request for the return address |
| link_idx | output | 5 | Register index for the return address (always 31) |
| link_value | output | 32 | Return address, PC + 4 |

## Verification
The assertions assume that `regs_equal` and `rs_value` are settled before each rising edge and belong to the instruction on `instr`. They also assume that `rst` is high for at least one edge before any instruction flow is checked. The bench changes all inputs only at falling edges and presents one instruction per cycle with matching comparator and register values. It walks the PC through a chain of addresses, so every expected target follows from the previous one: backward and forward offsets, both extreme offsets, a jump across a 256 MiB boundary, and a register jump to an address with the top nibble set.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned XLEN     = 32;
    localparam int unsigned OP_W     = 6;
    localparam int unsigned FN_W     = 6;
    localparam int unsigned BOFF_W   = 16;
    localparam int unsigned JFIELD_W = 26;
    localparam int unsigned RIDX_W   = 5;
    localparam int unsigned ISTEP    = 4;
    localparam int unsigned SEG_W    = XLEN - JFIELD_W - 2;

    localparam logic [OP_W-1:0]   OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0]   OPC_JMP     = 6'd2;
    localparam logic [OP_W-1:0]   OPC_JAL     = 6'd3;
    localparam logic [OP_W-1:0]   OPC_BEQ     = 6'd4;
    localparam logic [OP_W-1:0]   OPC_BNE     = 6'd5;
    localparam logic [FN_W-1:0]   FN_JREG     = 6'h08;
    localparam logic [RIDX_W-1:0] LINK_REG    = 5'd31;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JMP,
        FLOW_JAL,
        FLOW_JREG
    } flow_e;

    typedef struct packed {
        flow_e                kind;
        logic [BOFF_W-1:0]    boff;
        logic [JFIELD_W-1:0]  jfield;
    } flow_t;

    function automatic logic [XLEN-1:0] branch_disp(input logic [BOFF_W-1:0] off);
        return {{(XLEN-BOFF_W-2){off[BOFF_W-1]}}, off, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] jump_splice(input logic [XLEN-1:0]     seq,
                                                    input logic [JFIELD_W-1:0] field);
        return {seq[XLEN-1 -: SEG_W], field, 2'b00};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output flow_t           flow
);
    logic [OP_W-1:0] opc;
    logic [FN_W-1:0] fn;

    assign opc = instr[XLEN-1 -: OP_W];
    assign fn  = instr[FN_W-1:0];

    always_comb begin
        flow.boff   = instr[BOFF_W-1:0];
        flow.jfield = instr[JFIELD_W-1:0];
        unique case (opc)
            OPC_BEQ:     flow.kind = FLOW_BEQ;
            OPC_BNE:     flow.kind = FLOW_BNE;
            OPC_JMP:     flow.kind = FLOW_JMP;
            OPC_JAL:     flow.kind = FLOW_JAL;
            OPC_SPECIAL: flow.kind = (fn == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default:     flow.kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  flow_t           flow,
    input  logic            regs_equal,
    input  logic [XLEN-1:0] rs_value,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] seq_pc,
    output logic            is_call
);
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jd_pc;

    assign seq_pc  = pc + XLEN'(ISTEP);
    assign br_pc   = seq_pc + branch_disp(flow.boff);
    assign jd_pc   = jump_splice(seq_pc, flow.jfield);
    assign is_call = (flow.kind == FLOW_JAL);

    always_comb begin
        unique case (flow.kind)
            FLOW_BEQ:          next_pc = regs_equal  ? br_pc : seq_pc;
            FLOW_BNE:          next_pc = !regs_equal ? br_pc : seq_pc;
            FLOW_JMP, FLOW_JAL: next_pc = jd_pc;
            FLOW_JREG:         next_pc = rs_value;
            default:           next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0001_3880
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr,
    input  logic        regs_equal,
    input  logic [31:0] rs_value,
    output logic [31:0] pc_q,
    output logic [31:0] pc_next,
    output logic        link_wr,
    output logic [4:0]  link_idx,
    output logic [31:0] link_value
);
    flow_t           flow;
    logic [XLEN-1:0] seq_pc;
    logic            call;

    npc_decode u_decode (
        .instr (instr),
        .flow  (flow)
    );

    npc_target u_target (
        .pc         (pc_q),
        .flow       (flow),
        .regs_equal (regs_equal),
        .rs_value   (rs_value),
        .next_pc    (pc_next),
        .seq_pc     (seq_pc),
        .is_call    (call)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_VEC;
        else     pc_q <= pc_next;
    end

    assign link_wr    = call;
    assign link_idx   = LINK_REG;
    assign link_value = seq_pc;

    // R1: reset lands on the vector
    p_reset_vec_r1: assert property (@(posedge clk) rst |=> pc_q == RESET_VEC);

    // R2 / R10: plain instructions advance by one word
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] > 6'd5 || instr[31:26] == 6'd1 ||
         (instr[31:26] == 6'd0 && instr[5:0] != 6'h08))
        |=> pc_q == $past(pc_q) + 32'd4);

    // R5: a branch whose condition fails falls through
    p_fallthru_r5: assert property (@(posedge clk) disable iff (rst)
        ((instr[31:26] == 6'd4 && !regs_equal) || (instr[31:26] == 6'd5 && regs_equal))
        |=> pc_q == $past(pc_q) + 32'd4);

    // R8: register-indirect jump takes rs_value
    p_jreg_r8: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == 6'd0 && instr[5:0] == 6'h08) |=> pc_q == $past(rs_value));

    // R9: link write only for the call opcode
    p_link_only_call_r9: assert property (@(posedge clk) disable iff (rst)
        link_wr |-> instr[31:26] == 6'd3);

    // R7: the return address is the word after the current PC
    p_link_value_r7: assert property (@(posedge clk) disable iff (rst)
        link_wr |-> link_value == pc_q + 32'd4);
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;

    localparam logic [31:0] RVEC = 32'h0001_3880;

    typedef struct packed {
        logic [31:0] ins;
        logic        eq;
        logic [31:0] rs;
        logic [31:0] nxt;
        logic        we;
        logic [31:0] lnk;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TAB [0:NV-1] = '{
        '{32'h02324020, 1'b0, 32'h0,         32'h00013884, 1'b0, 32'h0,         8'd2},  // R2 add
        '{32'h12740002, 1'b1, 32'h0,         32'h00013890, 1'b0, 32'h0,         8'd3},  // R3 beq +2 taken
        '{32'h16740002, 1'b1, 32'h0,         32'h00013894, 1'b0, 32'h0,         8'd5},  // R5 bne not taken
        '{32'h1611FFFE, 1'b0, 32'h0,         32'h00013890, 1'b0, 32'h0,         8'd4},  // R4 bne -2 taken
        '{32'h1211FFFE, 1'b0, 32'h0,         32'h00013894, 1'b0, 32'h0,         8'd5},  // R5 beq not taken
        '{32'h08004E20, 1'b0, 32'h0,         32'h00013880, 1'b0, 32'h0,         8'd6},  // R6 j
        '{32'h0C004E28, 1'b0, 32'h0,         32'h000138A0, 1'b1, 32'h00013884,  8'd7},  // R7 jal
        '{32'h03E00008, 1'b0, 32'h00400100,  32'h00400100, 1'b0, 32'h0,         8'd8},  // R8 jr
        '{32'h00105100, 1'b0, 32'hFFFF0000,  32'h00400104, 1'b0, 32'h0,         8'd10}, // R10 sll
        '{32'h8E680020, 1'b1, 32'h0,         32'h00400108, 1'b0, 32'h0,         8'd9},  // R9 lw
        '{32'h03E00008, 1'b0, 32'hFC000010,  32'hFC000010, 1'b0, 32'h0,         8'd8},  // R8 jr high
        '{32'h08000003, 1'b0, 32'h0,         32'hF000000C, 1'b0, 32'h0,         8'd6},  // R6 nibble F
        '{32'h14007FFF, 1'b0, 32'h0,         32'hF002000C, 1'b0, 32'h0,         8'd4},  // R4 max offset
        '{32'h10008000, 1'b1, 32'h0,         32'hF0000010, 1'b0, 32'h0,         8'd3},  // R3 min offset
        '{32'h03E00008, 1'b0, 32'h0FFFFFFC,  32'h0FFFFFFC, 1'b0, 32'h0,         8'd8},  // R8
        '{32'h0C000001, 1'b0, 32'h0,         32'h10000004, 1'b1, 32'h10000000,  8'd7},  // R7 across 256MiB
        '{32'h21080008, 1'b1, 32'hDEAD0000,  32'h10000008, 1'b0, 32'h0,         8'd10}  // R10 funct 8, op 8
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic        regs_equal = 1'b0;
    logic [31:0] rs_value = 32'h0;
    logic [31:0] pc_q, pc_next, link_value;
    logic        link_wr;
    logic [4:0]  link_idx;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    npc_unit #(.RESET_VEC(RVEC)) i_npc_unit (
        .clk        (clk),
        .rst        (rst),
        .instr      (instr),
        .regs_equal (regs_equal),
        .rs_value   (rs_value),
        .pc_q       (pc_q),
        .pc_next    (pc_next),
        .link_wr    (link_wr),
        .link_idx   (link_idx),
        .link_value (link_value)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] cur;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 pc after reset", pc_q, RVEC);
        cur = RVEC;

        for (int k = 0; k < NV; k++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", TAB[k].req, k);
            instr      = TAB[k].ins;
            regs_equal = TAB[k].eq;
            rs_value   = TAB[k].rs;
            #2;
            check({tg, " pc_q"},    pc_q, cur);
            check({tg, " pc_next"}, pc_next, TAB[k].nxt);
            check({tg, " link_wr (R9)"}, {31'b0, link_wr}, {31'b0, TAB[k].we});
            if (TAB[k].we) begin
                check({tg, " link_value (R7)"}, link_value, TAB[k].lnk);
                check({tg, " link_idx (R7)"}, {27'b0, link_idx}, 32'd31);
            end
            @(posedge clk);
            #2;
            check({tg, " pc after edge (R11)"}, pc_q, TAB[k].nxt);
            cur = TAB[k].nxt;
            @(negedge clk);
        end

        // R1: reset wins over a jump presented on the same edge
        instr = 32'h08000003;
        rst   = 1'b1;
        @(posedge clk);
        #2;
        check("R1 reset over jump", pc_q, RVEC);
        @(negedge clk);
        rst = 1'b0;
        // R5: beq with flag low right after reset
        instr = 32'h10000010;
        regs_equal = 1'b0;
        #2;
        check("R5 beq flag low after reset", pc_next, RVEC + 32'd4);
        @(posedge clk);
        #2;
        check("R5 pc after fallthrough", pc_q, RVEC + 32'd4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule